// File: doc/BRIEF.md
# Programmable Butterfly Lookup Network

This block is a purely combinational 64-bit permutation-and-logic network made of six butterfly stages. The stages are ordered by partner distance 1, 2, 4, 8, 16 and 32, and each stage can be switched on or bypassed. An active stage rebuilds every bit of its vector. It combines the bit with its partner bit at the stage's distance through a 2-input truth table. The table comes from an 8-bit immediate that carries two nibble-sized tables. Which nibble a bit uses depends on whether the bit sits in the lower or the upper half of its chunk at that stage.

The starting vector is either the supplied operand or, when the operand is flagged as absent, an alternating constant. Either one may be complemented before the first stage. The low six bits of a second operand pick which stages take part. With a truth table that forwards the partner bit, the network acts as a generalized bit reverse. With other tables it can smear, fill or combine bit groups in one pass.

Top module: `grevlut_net`

## Requirements
- R1: When `ra_zero` is 1, the starting vector is 0x5555555555555555 (even bit positions set) and `ra` is ignored; when it is 0, the starting vector is `ra`.
- R2: When `invert` is 1, the starting vector is bitwise complemented before any stage.
- R3: Only `rb[5:0]` affects the result; `rb[63:6]` has no effect.
- R4: With `rb[5:0]` equal to 0, `result` equals the (possibly complemented) starting vector.
- R5: Stage i (bit i of `rb`, step = 1<<i) computes output bit j from input bit j (operand a) and input bit j XOR step (operand b).
- R6: In stage i, bits with (j & step) == 0 use `imm[3:0]` as their truth table, and all other bits use `imm[7:4]`.
- R7: A truth-table lookup returns nibble bit index {b,a}, i.e. b*2 + a.
- R8: Enabled stages are applied in increasing order of step, each stage reading its whole input before any output bit is formed.
- R9: With `imm` = 0xCC (every lookup returns b), `result` bit j equals starting bit (j XOR `rb[5:0]`), a generalized bit reverse; with `imm` = 0xAA (every lookup returns a), `result` equals the starting vector.
- R10: With at least one stage enabled, `imm` = 0x00 gives an all-zero result and `imm` = 0xFF gives an all-one result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ra | input | 64 | Source operand used as the starting vector |
| ra_zero | input | 1 | Operand absent: use the alternating constant instead of `ra` |
| rb | input | 64 | Stage selector; only the low six bits are used |
| imm | input | 8 | Two truth tables: low nibble for lower-half bits, high nibble for upper-half bits |
| invert | input | 1 | Complement the starting vector |
| result | output | 64 | Network output |

## Verification
The in-design assertions are immediate checks inside combinational processes. They assume all inputs carry known values, and each one is guarded so that it is skipped while any input is unknown. The bench drives every input to a defined value before the first evaluation and changes inputs only on the falling clock edge, so every checked evaluation sees settled, known operands. Random vectors use the full 64-bit range of `rb`, which also exercises the bits that must be ignored.

// File: rtl/grevlut_pkg.sv
package grevlut_pkg;

  localparam int unsigned DATA_W = 64;
  localparam int unsigned IMM_W  = 8;

  // The immediate viewed as its two truth tables.
  typedef struct packed {
    logic [3:0] upper_tbl;
    logic [3:0] lower_tbl;
  } lut_pair_t;

endpackage

// File: rtl/grevlut_seed.sv
module grevlut_seed #(
  parameter int unsigned W = grevlut_pkg::DATA_W
) (
  input  logic [W-1:0] ra,
  input  logic         ra_zero,
  input  logic         invert,
  output logic [W-1:0] seed
);

  logic [W-1:0] alt_const;
  logic [W-1:0] base;

  // Alternating constant: even positions set.
  for (genvar k = 0; k < int'(W); k++) begin : g_alt
    assign alt_const[k] = ((k % 2) == 0);
  end

  assign base = ra_zero ? alt_const : ra;
  assign seed = invert ? ~base : base;

  always_comb begin
    if (!$isunknown({ra, ra_zero, invert})) begin
      if (ra_zero) begin
        AST_SEED_CONST: assert ((seed ^ {W{invert}}) == alt_const) else $error("seed constant wrong"); // R1
      end
      if (invert) begin
        AST_SEED_INV: assert ((seed & base) == '0) else $error("seed not complemented"); // R2
      end
    end
  end

endmodule

// File: rtl/grevlut_stage.sv
module grevlut_stage #(
  parameter int unsigned W    = grevlut_pkg::DATA_W,
  parameter int unsigned STEP = 1
) (
  input  logic                  en,
  input  grevlut_pkg::lut_pair_t tbl,
  input  logic [W-1:0]          din,
  output logic [W-1:0]          dout
);

  logic [W-1:0] mixed;

  for (genvar j = 0; j < int'(W); j++) begin : g_bit
    localparam int unsigned PARTNER = j ^ STEP;
    localparam bit          UPPER   = ((j & STEP) != 0);
    logic [3:0] nib;
    assign nib      = UPPER ? tbl.upper_tbl : tbl.lower_tbl;
    assign mixed[j] = nib[{din[PARTNER], din[j]}];
  end

  assign dout = en ? mixed : din;

  logic [W-1:0] swapped;
  always_comb begin
    for (int k = 0; k < int'(W); k++) begin
      swapped[k] = din[k ^ int'(STEP)];
    end
    if (!$isunknown({en, tbl, din})) begin
      if (tbl == 8'hAA) begin
        AST_STAGE_PASS: assert (dout == din) else $error("select-a table altered data"); // R9
      end
      if (en && tbl == 8'hCC) begin
        AST_STAGE_SWAP: assert (dout == swapped) else $error("select-b table not a swap"); // R5
      end
      if (!en) begin
        AST_STAGE_SKIP: assert (dout == din) else $error("disabled stage changed data"); // R4
      end
    end
  end

endmodule

// File: rtl/grevlut_net.sv
module grevlut_net #(
  parameter int unsigned W     = grevlut_pkg::DATA_W,
  parameter int unsigned IMM_W = grevlut_pkg::IMM_W
) (
  input  logic [W-1:0]     ra,
  input  logic             ra_zero,
  input  logic [W-1:0]     rb,
  input  logic [IMM_W-1:0] imm,
  input  logic             invert,
  output logic [W-1:0]     result
);

  localparam int unsigned NST = $clog2(W);

  grevlut_pkg::lut_pair_t tbl;
  logic [NST-1:0]         stage_en;
  logic [W-1:0]           chain [NST+1];
  logic                   unused_rb;

  assign tbl       = grevlut_pkg::lut_pair_t'(imm);
  assign stage_en  = rb[NST-1:0];
  assign unused_rb = ^rb[W-1:NST];

  grevlut_seed #(.W(W)) u_seed (
    .ra      (ra),
    .ra_zero (ra_zero),
    .invert  (invert),
    .seed    (chain[0])
  );

  // Stages chained in ascending step order.
  for (genvar i = 0; i < int'(NST); i++) begin : g_stage
    grevlut_stage #(.W(W), .STEP(1 << i)) u_stage (
      .en   (stage_en[i]),
      .tbl  (tbl),
      .din  (chain[i]),
      .dout (chain[i+1])
    );
  end

  assign result = chain[NST];

  always_comb begin
    if (!$isunknown({ra, ra_zero, rb, imm, invert})) begin
      if (stage_en == '0) begin
        AST_NO_STAGE: assert (result == chain[0]) else $error("bypass altered data"); // R4
      end
      if (stage_en != '0 && imm == '0) begin
        AST_FILL_ZERO: assert (result == '0) else $error("zero table not zero"); // R10
      end
      if (stage_en != '0 && imm == '1) begin
        AST_FILL_ONE: assert (result == '1) else $error("one table not ones"); // R10
      end
    end
  end

endmodule

// File: tb/grevlut_net_test.sv
`timescale 1ns/1ps
module grevlut_net_test;

  logic        clk;
  logic        rst_n;
  logic [63:0] ra;
  logic        ra_zero;
  logic [63:0] rb;
  logic [7:0]  imm;
  logic        invert;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  grevlut_net uut (
    .ra      (ra),
    .ra_zero (ra_zero),
    .rb      (rb),
    .imm     (imm),
    .invert  (invert),
    .result  (result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] model(logic [63:0] a_in, logic z, logic [63:0] sel,
                                        logic [7:0] tb_imm, logic inv);
    logic [63:0] x, y;
    x = z ? 64'h5555_5555_5555_5555 : a_in;
    if (inv) x = ~x;
    for (int i = 0; i < 6; i++) begin
      if (sel[i]) begin
        for (int j = 0; j < 64; j++) begin
          int step;
          logic [3:0] nib;
          logic a, b;
          step = 1 << i;
          nib  = ((j & step) == 0) ? tb_imm[3:0] : tb_imm[7:4];
          a    = x[j];
          b    = x[j ^ step];
          y[j] = nib[{b, a}];
        end
        x = y;
      end
    end
    return x;
  endfunction

  function automatic logic [63:0] grev(logic [63:0] x, logic [5:0] sh);
    logic [63:0] y;
    for (int j = 0; j < 64; j++) y[j] = x[j ^ int'(sh)];
    return y;
  endfunction

  task automatic apply(logic [63:0] a_in, logic z, logic [63:0] sel, logic [7:0] t, logic inv);
    @(negedge clk);
    ra = a_in; ra_zero = z; rb = sel; imm = t; invert = inv;
    #1;
  endtask

  task automatic check(string req, logic [63:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, result, exp);
    end
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    logic [63:0] v, w, r0;
    ra = '0; ra_zero = 0; rb = '0; imm = '0; invert = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    sd = $urandom(32'd4242);

    // R4: idle inputs give zero through a bypassed network
    apply(64'h0, 0, 64'h0, 8'h00, 0);
    check("R4 idle", 64'h0);
    apply(64'hDEAD_BEEF_0123_4567, 0, 64'h0, 8'h5A, 0);
    check("R4 bypass", 64'hDEAD_BEEF_0123_4567);
    // R1: constant seed, ra ignored
    apply(64'hFFFF_0000_FFFF_0000, 1, 64'h0, 8'h37, 0);
    check("R1 seed", 64'h5555_5555_5555_5555);
    // R2: inversion of operand and of constant
    apply(64'h0F0F_0000_1234_8000, 0, 64'h0, 8'h00, 1);
    check("R2 invert ra", ~64'h0F0F_0000_1234_8000);
    apply(64'h1, 1, 64'h0, 8'h00, 1);
    check("R2 invert seed", 64'hAAAA_AAAA_AAAA_AAAA);
    // R5 R6 R7: stage 0, lower bits take AND, upper take XOR
    apply(64'h0000_0000_0000_00B6, 0, 64'h1, 8'h68, 0);
    check("R7 single stage", model(64'hB6, 0, 64'h1, 8'h68, 0));
    // R6: lower table ones, upper table zeros on step 32
    apply(64'h0, 0, 64'h20, 8'h0F, 0);
    check("R6 nibble select", 64'h0000_0000_FFFF_FFFF);
    // R5: stage 3 partner at distance 8, OR table
    apply(64'h0000_0000_0000_0001, 0, 64'h8, 8'hEE, 0);
    check("R5 partner", 64'h0000_0000_0000_0101);
    // R8: ascending order: OR smear at step1 then step2
    apply(64'h1, 0, 64'h3, 8'hEE, 0);
    check("R8 order", 64'hF);
    apply(64'h1, 0, 64'h3, 8'h8E, 0);
    check("R8 order model", model(64'h1, 0, 64'h3, 8'h8E, 0));
    // R3: upper rb bits ignored
    apply(64'h0123_4567_89AB_CDEF, 0, 64'h15, 8'h96, 0);
    r0 = result;
    apply(64'h0123_4567_89AB_CDEF, 0, 64'hFFFF_FFFF_FFFF_FFD5, 8'h96, 0);
    check("R3 high rb ignored", r0);
    // R9: generalized reverse and identity
    apply(64'h0123_4567_89AB_CDEF, 0, 64'h3F, 8'hCC, 0);
    check("R9 full reverse", grev(64'h0123_4567_89AB_CDEF, 6'h3F));
    apply(64'h0123_4567_89AB_CDEF, 0, 64'h3F, 8'hAA, 0);
    check("R9 identity", 64'h0123_4567_89AB_CDEF);
    // R10: constant tables
    apply(64'hCAFE_F00D_1234_5678, 0, 64'h4, 8'h00, 0);
    check("R10 zeros", 64'h0);
    apply(64'h0, 1, 64'h20, 8'hFF, 1);
    check("R10 ones", 64'hFFFF_FFFF_FFFF_FFFF);

    for (int n = 0; n < 40; n++) begin
      v = {$urandom, $urandom};
      w = {$urandom, $urandom};
      apply(v, 0, w, 8'hCC, $urandom % 2);
      check("R9 random reverse", grev(invert ? ~v : v, w[5:0]));
    end
    for (int n = 0; n < 300; n++) begin
      logic z, iv;
      logic [7:0] t;
      v  = {$urandom, $urandom};
      w  = {$urandom, $urandom};
      t  = 8'($urandom);
      z  = ($urandom % 8) == 0;
      iv = $urandom % 2;
      apply(v, z, w, t, iv);
      check("R7 random", model(v, z, w, t, iv));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule